// File: doc/BRIEF.md
# Mapped Byte/Word DMA Transfer Engine

This engine moves a block of data between a device-side buffer port and a 16-bit word memory. It is started with a bus byte address, a byte count, a direction and a unit size: single bytes or 16-bit words. Each bus address is either passed through an external address-translation port or used directly as a physical byte address. The engine steps through the block one element at a time. In byte mode it steers each byte into the correct half of the memory word.

The block stops when the data would fall outside the installed memory, given by the `MEM_BYTES` parameter, which must be even. It then reports how many bytes were not moved, together with a one-cycle done pulse.

The memory port is synchronous, with one cycle of read latency and a write enable for each byte lane. Data written into memory comes from a valid/ready source port. Data read from memory leaves through a valid/ready sink port.

Top module: `dma_xfer_engine`

## Requirements
- R1: In word mode, bit 0 of the start address is forced to 0 and the byte count is rounded down to an even value before any transfer; a word-mode count of 1 moves nothing and reports residual 0.
- R2: In byte mode, an odd address uses memory bits [15:8], with `mem_be` = 2'b10 on a write. An even address uses bits [7:0], with `mem_be` = 2'b01. A byte read is delivered on `dst_data[7:0]` with `dst_data[15:8]` = 0. A byte write takes `src_data[7:0]`.
- R3: A byte write leaves the other byte of the target memory word unchanged.
- R4: The bus address advances by 1 after each byte and by 2 after each word. A memory write happens in every cycle in which the source offers data, with no idle cycle between writes.
- R5: With translation on, every address is sent out on `map_addr`. At the first translated address that is at or above `MEM_BYTES`, the engine stops and reports the bytes not yet moved. No memory access is ever made at or above `MEM_BYTES`.
- R6: With translation off and the block ending within memory, the whole block moves and the residual is 0.
- R7: With translation off, if the start lies within memory but the end does not, the bytes below `MEM_BYTES` move. The residual is the number of bytes above that limit.
- R8: With translation off, if the start is at or above `MEM_BYTES`, nothing moves and the residual equals the whole (rounded) count.
- R9: `done` is high for exactly one cycle at the end of each transfer, with `residual` valid from that cycle. `busy` is high from the cycle after `start` until `done`.
- R10: A `start` while `busy` is high is ignored; the running transfer finishes with its original parameters.
- R11: After reset, `busy`, `done`, `residual`, `mem_en`, `src_ready` and `dst_valid` are 0.
- R12: A read returns data one cycle after issue. `dst_valid` and `dst_data` stay unchanged until `dst_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| dir_to_mem | input | 1 | 1: source port to memory, 0: memory to sink port |
| word_mode | input | 1 | 1: 16-bit words, 0: bytes |
| use_map | input | 1 | 1: translate each address through the map port |
| bus_addr | input | AW | Start bus byte address |
| byte_count | input | CW | Number of bytes to move |
| map_addr | output | AW | Bus address presented for translation |
| map_phys | input | PW | Translated physical byte address (combinational reply) |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (else read) |
| mem_be | output | 2 | Byte-lane write enables, bit 1 = [15:8] |
| mem_addr | output | MWA | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after the read |
| src_valid | input | 1 | Source data available |
| src_data | input | 16 | Source data |
| src_ready | output | 1 | Source data taken this cycle |
| dst_valid | output | 1 | Sink data available |
| dst_data | output | 16 | Sink data |
| dst_ready | input | 1 | Sink takes data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| residual | output | CW | Bytes not moved by the last transfer |

## Verification
Writes are tried at odd and even byte addresses, and at an odd word start with an odd count. These show lane choice, the preservation of the neighbouring byte, and alignment. Reads are tried in both unit sizes, with the sink stalling on alternate cycles, which separates correct holding of read data from lost or repeated elements.

The untranslated cases place the block fully inside memory, across the memory limit and wholly beyond it. This pins down each of the three residual rules. A translated block whose mapped addresses cross the limit part-way through shows that the stop is decided address by address. A second `start` during a stalled read must leave the data and the residual unchanged.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_RCAP, ST_RSEND} dma_state_t;

  // lane enables for one element: whole word, or the lane chosen by address bit 0
  function automatic logic [1:0] lane_enable(input logic is_word, input logic odd);
    if (is_word) return 2'b11;
    return odd ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [7:0] pick_byte(input logic [15:0] w, input logic odd);
    return odd ? w[15:8] : w[7:0];
  endfunction
endpackage

// File: rtl/dma_span.sv
module dma_span #(
  parameter int AW = 18,
  parameter int CW = 16,
  parameter int MEM_BYTES = 4096
) (
  input  logic          word_mode,
  input  logic          use_map,
  input  logic [AW-1:0] addr_in,
  input  logic [CW-1:0] count_in,
  output logic [AW-1:0] addr_al,
  output logic [CW-1:0] run_bytes,
  output logic [CW-1:0] tail_bytes
);
  localparam int EW = ((AW > CW) ? AW : CW) + 2;

  logic [CW-1:0] cnt_al;
  logic [EW-1:0] first, last, limit;

  always_comb begin
    addr_al = word_mode ? {addr_in[AW-1:1], 1'b0} : addr_in;
    cnt_al  = word_mode ? {count_in[CW-1:1], 1'b0} : count_in;
    first   = EW'(addr_al);
    last    = EW'(addr_al) + EW'(cnt_al);
    limit   = EW'(MEM_BYTES);
    if (use_map || last <= limit) begin
      run_bytes  = cnt_al;
      tail_bytes = '0;
    end else if (first < limit) begin
      run_bytes  = CW'(limit - first);
      tail_bytes = CW'(last - limit);
    end else begin
      run_bytes  = '0;
      tail_bytes = cnt_al;
    end
  end
endmodule

// File: rtl/dma_lane.sv
module dma_lane (
  input  logic        is_word,
  input  logic        wr_odd,
  input  logic        rd_odd,
  input  logic [15:0] src_word,
  input  logic [15:0] mem_word,
  output logic [1:0]  wr_be,
  output logic [15:0] wr_data,
  output logic [15:0] rd_data
);
  import dma_pkg::*;

  always_comb begin
    wr_be   = lane_enable(is_word, wr_odd);
    wr_data = is_word ? src_word : {src_word[7:0], src_word[7:0]};
    rd_data = is_word ? mem_word : {8'h00, pick_byte(mem_word, rd_odd)};
  end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
  parameter int AW = 18,
  parameter int PW = 22,
  parameter int CW = 16,
  parameter int MEM_BYTES = 4096,
  localparam int MWA = $clog2(MEM_BYTES) - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           dir_to_mem,
  input  logic           word_mode,
  input  logic           use_map,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  byte_count,
  output logic [AW-1:0]  map_addr,
  input  logic [PW-1:0]  map_phys,
  output logic           mem_en,
  output logic           mem_we,
  output logic [1:0]     mem_be,
  output logic [MWA-1:0] mem_addr,
  output logic [15:0]    mem_wdata,
  input  logic [15:0]    mem_rdata,
  input  logic           src_valid,
  input  logic [15:0]    src_data,
  output logic           src_ready,
  output logic           dst_valid,
  output logic [15:0]    dst_data,
  input  logic           dst_ready,
  output logic           busy,
  output logic           done,
  output logic [CW-1:0]  residual
);
  import dma_pkg::*;

  dma_state_t    st;
  logic [AW-1:0] cur;
  logic [CW-1:0] left, tail;
  logic          dir_r, word_r, map_r, rd_odd_r;
  logic [15:0]   hold;

  logic [AW-1:0] start_addr;
  logic [CW-1:0] start_run, start_tail;

  dma_span #(.AW(AW), .CW(CW), .MEM_BYTES(MEM_BYTES)) u_span (
    .word_mode (word_mode),
    .use_map   (use_map),
    .addr_in   (bus_addr),
    .count_in  (byte_count),
    .addr_al   (start_addr),
    .run_bytes (start_run),
    .tail_bytes(start_tail)
  );

  // named internal events
  logic [PW-1:0] acc_phys;
  logic          nxm_hit, at_end, finish, wr_fire, rd_issue, advance, accept;
  logic [1:0]    lane_be;
  logic [15:0]   lane_wdata, lane_rdata;

  always_comb begin
    acc_phys = map_r ? map_phys : PW'(cur);
    nxm_hit  = map_r && (acc_phys >= PW'(MEM_BYTES));
    at_end   = (left == '0);
    finish   = (st == ST_RUN) && (at_end || nxm_hit);
    wr_fire  = (st == ST_RUN) && !finish && dir_r && src_valid;
    rd_issue = (st == ST_RUN) && !finish && !dir_r;
    advance  = wr_fire || (st == ST_RCAP);
    accept   = (st == ST_IDLE) && start;
  end

  dma_lane u_lane (
    .is_word (word_r),
    .wr_odd  (acc_phys[0]),
    .rd_odd  (rd_odd_r),
    .src_word(src_data),
    .mem_word(mem_rdata),
    .wr_be   (lane_be),
    .wr_data (lane_wdata),
    .rd_data (lane_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur      <= '0;
      left     <= '0;
      tail     <= '0;
      dir_r    <= 1'b0;
      word_r   <= 1'b0;
      map_r    <= 1'b0;
      rd_odd_r <= 1'b0;
      hold     <= '0;
      done     <= 1'b0;
      residual <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        st     <= ST_RUN;
        cur    <= start_addr;
        left   <= start_run;
        tail   <= start_tail;
        dir_r  <= dir_to_mem;
        word_r <= word_mode;
        map_r  <= use_map;
      end
      if (finish) begin
        st       <= ST_IDLE;
        done     <= 1'b1;
        residual <= left + tail;
      end
      if (rd_issue) begin
        st       <= ST_RCAP;
        rd_odd_r <= acc_phys[0];
      end
      if (st == ST_RCAP) begin
        hold <= lane_rdata;
        st   <= ST_RSEND;
      end
      if (st == ST_RSEND && dst_ready) st <= ST_RUN;
      if (advance) begin
        cur  <= cur + (word_r ? AW'(2) : AW'(1));
        left <= left - (word_r ? CW'(2) : CW'(1));
      end
    end
  end

  assign map_addr  = cur;
  assign mem_en    = wr_fire || rd_issue;
  assign mem_we    = wr_fire;
  assign mem_be    = wr_fire ? lane_be : 2'b11;
  assign mem_addr  = acc_phys[MWA:1];
  assign mem_wdata = lane_wdata;
  assign src_ready = wr_fire;
  assign dst_valid = (st == ST_RSEND);
  assign dst_data  = hold;
  assign busy      = (st != ST_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R9
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !word_r) |-> ($countones(mem_be) == 1));  // R2
  AST_NO_ACCESS_BEYOND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (acc_phys < PW'(MEM_BYTES)));  // R5
  AST_SRC_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (dir_r && mem_en && mem_we));  // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(dir_r) && $stable(word_r) && $stable(map_r)));  // R10
  AST_DST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data)));  // R12
endmodule

// File: tb/tb_dma_xfer_engine.sv
module tb_dma_xfer_engine;
  localparam int AW = 18, PW = 22, CW = 16, MEM_BYTES = 4096;
  localparam int MWA = $clog2(MEM_BYTES) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, dir_to_mem = 1'b0, word_mode = 1'b0, use_map = 1'b0;
  logic [AW-1:0] bus_addr = '0, map_addr;
  logic [CW-1:0] byte_count = '0, residual;
  logic [PW-1:0] map_phys;
  logic mem_en, mem_we, src_ready, dst_valid, busy, done;
  logic [1:0] mem_be;
  logic [MWA-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = '0, src_data, dst_data;
  logic src_en = 1'b0, dst_en = 1'b0, throttle = 1'b0;
  logic src_valid, dst_ready;

  int checks = 0, errors = 0, n_src = 0, n_rx = 0, cyc = 0, n_mem_wr = 0;
  logic [15:0] mem [0:(MEM_BYTES/2)-1];
  logic [15:0] rx [0:15];

  always #2 clk = ~clk;

  function automatic logic [15:0] pat(input int i);
    return 16'h3C00 ^ 16'(i * 273);
  endfunction

  assign map_phys  = PW'(map_addr) + PW'('h400);
  assign src_valid = src_en;
  assign src_data  = pat(n_src);
  assign dst_ready = dst_en && (!throttle || cyc[0]);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_en) begin
      if (mem_we) begin
        n_mem_wr <= n_mem_wr + 1;
        if (mem_be[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
      end else mem_rdata <= mem[mem_addr];
    end
    if (src_valid && src_ready) n_src <= n_src + 1;
    if (dst_valid && dst_ready) begin
      rx[n_rx[3:0]] <= dst_data;
      n_rx <= n_rx + 1;
    end
  end

  dma_xfer_engine #(.AW(AW), .PW(PW), .CW(CW), .MEM_BYTES(MEM_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_to_mem(dir_to_mem),
    .word_mode(word_mode), .use_map(use_map), .bus_addr(bus_addr),
    .byte_count(byte_count), .map_addr(map_addr), .map_phys(map_phys),
    .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .src_valid(src_valid),
    .src_data(src_data), .src_ready(src_ready), .dst_valid(dst_valid),
    .dst_data(dst_data), .dst_ready(dst_ready), .busy(busy), .done(done),
    .residual(residual));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [CW-1:0] got_res;
  int done_width;

  // pulse start, wait for done, record residual and width of the done pulse
  task automatic run_xfer(input logic d, input logic w, input logic m,
                          input logic [AW-1:0] a, input logic [CW-1:0] c);
    int t = 0;
    @(negedge clk);
    dir_to_mem = d; word_mode = w; use_map = m; bus_addr = a; byte_count = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    if (t >= 2000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    got_res = residual;
    @(negedge clk);
    done_width = done ? 2 : 1;
  endtask

  task automatic t_reset;
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 residual", residual, 0);
    chk("R11 mem_en", mem_en, 0);
    chk("R11 src_ready", src_ready, 0);
    chk("R11 dst_valid", dst_valid, 0);
  endtask

  task automatic t_word_align;
    int b = n_src;
    int w0 = n_mem_wr;
    mem['h83] = 16'h5555;
    src_en = 1'b1;
    run_xfer(1, 1, 0, 'h101, 7);
    src_en = 1'b0;
    chk("R1 word0", mem['h80], pat(b));
    chk("R1 word2", mem['h82], pat(b + 2));
    chk("R1 untouched", mem['h83], 16'h5555);
    chk("R4 write cycles", n_mem_wr - w0, 3);
    chk("R6 residual", got_res, 0);
    chk("R9 done width", done_width, 1);
    b = n_src;
    src_en = 1'b1;
    run_xfer(1, 1, 0, 'h200, 1);
    src_en = 1'b0;
    chk("R1 count one", n_src - b, 0);
    chk("R1 count one res", got_res, 0);
  endtask

  task automatic t_byte_write;
    int b = n_src;
    logic [7:0] d0 = pat(b)[7:0];
    logic [7:0] d1 = pat(b + 1)[7:0];
    logic [7:0] d2 = pat(b + 2)[7:0];
    mem['h100] = 16'hAAAA; mem['h101] = 16'hAAAA;
    src_en = 1'b1;
    run_xfer(1, 0, 0, 'h201, 3);
    src_en = 1'b0;
    chk("R2 odd high lane", mem['h100], {d0, 8'hAA});
    chk("R3 pair", mem['h101], {d2, d1});
    chk("R4 byte count", n_src - b, 3);
  endtask

  task automatic t_reads;
    int r0 = n_rx;
    mem['h180] = 16'h1234; mem['h181] = 16'hBEEF;
    dst_en = 1'b1;
    run_xfer(0, 0, 0, 'h301, 2);
    chk("R2 odd read", rx[r0[3:0]], 16'h0012);
    chk("R2 even read", rx[4'(r0 + 1)], 16'h00EF);
    mem['h190] = 16'h1111; mem['h191] = 16'h2222; mem['h192] = 16'h3333;
    r0 = n_rx;
    throttle = 1'b1;
    run_xfer(0, 1, 0, 'h320, 6);
    throttle = 1'b0;
    dst_en = 1'b0;
    chk("R12 count", n_rx - r0, 3);
    chk("R12 w0", rx[r0[3:0]], 16'h1111);
    chk("R12 w1", rx[4'(r0 + 1)], 16'h2222);
    chk("R12 w2", rx[4'(r0 + 2)], 16'h3333);
  endtask

  task automatic t_limits;
    int b = n_src;
    src_en = 1'b1;
    run_xfer(1, 1, 0, 'hFFC, 8);
    chk("R7 residual", got_res, 4);
    chk("R7 moved", n_src - b, 2);
    chk("R7 last word", mem['h7FF], pat(b + 1));
    b = n_src;
    run_xfer(1, 1, 0, 'h1002, 7);
    chk("R8 residual", got_res, 6);
    chk("R8 moved", n_src - b, 0);
    src_en = 1'b0;
  endtask

  task automatic t_mapped;
    int b = n_src;
    src_en = 1'b1;
    run_xfer(1, 1, 1, 'h010, 2);
    chk("R5 translated", mem['h208], pat(b));
    b = n_src;
    mem['h7FE] = 16'h0; mem['h7FF] = 16'h0;
    run_xfer(1, 0, 1, 'hBFC, 8);
    src_en = 1'b0;
    chk("R5 residual", got_res, 4);
    chk("R5 moved", n_src - b, 4);
    chk("R5 bytes", mem['h7FF], {pat(b + 3)[7:0], pat(b + 2)[7:0]});
  endtask

  task automatic t_busy_start;
    int r0 = n_rx, b = n_src, t = 0;
    mem['h1A0] = 16'hCAFE; mem['h1A1] = 16'hF00D;
    @(negedge clk);
    dir_to_mem = 0; word_mode = 1; use_map = 0; bus_addr = 'h340; byte_count = 4;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 busy", busy, 1);
    dir_to_mem = 1; word_mode = 0; bus_addr = 'h10; byte_count = 9; start = 1'b1;
    src_en = 1'b1;
    @(negedge clk);
    start = 1'b0; src_en = 1'b0;
    dst_en = 1'b1;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk("R10 residual", residual, 0);
    @(negedge clk);
    dst_en = 1'b0;
    chk("R10 reads", n_rx - r0, 2);
    chk("R10 w1", rx[4'(r0 + 1)], 16'hF00D);
    chk("R10 no source", n_src - b, 0);
    chk("R10 idle", busy, 0);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM_BYTES / 2; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_word_align;
    t_byte_write;
    t_reads;
    t_limits;
    t_mapped;
    t_busy_start;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule